// File: doc/BRIEF.md
# Transparent serial sync framer

This block starts and frames transfers on a bit-serial channel that carries raw, unframed data. It runs on the serial bit clock. A receive side turns incoming bits into bytes, and a transmit side turns bytes into outgoing bits. Each side can begin a transfer in one of two ways. The first is an in-line sync word of 8 or 16 bits, taken from a pattern input. The second is an external start line: carrier-detect for the receiver and clear-to-send for the transmitter.

A 2-bit length code selects the start method, and it applies to both sides. A code of zero turns the in-line sync word off and hands control to the external lines. Each external line has two options of its own. The first is pulse or envelope behaviour: a single assertion starts a stream that never stops, or the line must stay asserted for the whole frame. The second is synchronous or asynchronous sampling: the line is used on the same edge, or it passes through a two-flop synchronizer first. When the in-line sync word is used, the transmitter sends it ahead of the data, so a receiver on the far end can lock onto it.

Top module: `sync_framer_top`

## Requirements
- R1: While reset is asserted, and just after it, `rx_valid` is 0, `tx_ready` is 0 and `tx_bit` is 1.
- R2: With `sync_len` = 01, the receiver compares the last 8 received bits against `sync_pattern[7:0]`. With 10 or 11, it compares the last 16 bits against all of `sync_pattern`. The oldest received bit lines up with the pattern MSB. A match only counts once at least that many bits have arrived since reset.
- R3: After a match, the first data bit is the bit sampled on the edge that follows the match edge. Data bits are packed MSB-first. A completed byte appears on `rx_byte`, and `rx_valid` is high for exactly one cycle, in the cycle after the edge that sampled the byte's eighth bit.
- R4: With `sync_len` = 00, reception begins with the bit sampled on the first edge where the sampled carrier-detect is high. That bit is the first data bit.
- R5: In receive pulse mode (`rx_pulse` = 1), carrier-detect is ignored once reception has started.
- R6: In receive envelope mode, on any edge where the sampled carrier-detect is low, the bit is not stored and any partial byte is dropped. The receiver then waits for the next assertion.
- R7: With the synchronous sample bit set to 1, a start line is used on the same edge as the data bit. With it set to 0, the line passes through two flops, so the value acted on is the one that was present two edges earlier. This applies to both carrier-detect and clear-to-send.
- R8: With in-line sync, the transmitter leaves its wait state on the first edge where `tx_valid` is high. Starting on that edge, it sends the 8 or 16 pattern bits MSB-first, one per edge. The data bytes follow with no gap.
- R9: With `sync_len` = 00, the first edge where the sampled clear-to-send is high moves the transmitter into its data state. On that edge it still sends a 1. It can take bytes from the next cycle on.
- R10: `tx_ready` is high only in the data state when no byte is being sent. A byte is taken on an edge where `tx_ready` and `tx_valid` are both high. Its bits go out MSB-first on that edge and the seven edges after it.
- R11: `tx_bit` is 1 whenever the transmitter has not started, or has no byte to send.
- R12: In transmit envelope mode, on an edge where the sampled clear-to-send is low, `tx_bit` goes to 1 and the rest of the byte in progress is dropped. `tx_ready` stays low, and the transmitter waits for a new start.
- R13: In transmit pulse mode, clear-to-send is ignored once the transmitter is in its data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| cd_in | input | 1 | Carrier-detect start line for the receiver |
| cts_in | input | 1 | Clear-to-send start line for the transmitter |
| sync_len | input | 2 | 00 external lines, 01 8-bit pattern, 10/11 16-bit pattern |
| sync_pattern | input | 16 | Sync word |
| rx_pulse | input | 1 | 1 = pulse mode, 0 = envelope mode for carrier-detect |
| tx_pulse | input | 1 | 1 = pulse mode, 0 = envelope mode for clear-to-send |
| rx_sync_sample | input | 1 | 1 = sample carrier-detect synchronously, 0 = through synchronizer |
| tx_sync_sample | input | 1 | 1 = sample clear-to-send synchronously, 0 = through synchronizer |
| rx_byte | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_byte` holds a byte |
| tx_ready | output | 1 | Transmitter takes `tx_byte` on this edge |
| tx_bit | output | 1 | Transmitted serial data bit |

## Verification
Two situations are the hardest to reach from the ports. One is an envelope frame that ends partway through a byte while the start line is going through the two-flop synchronizer, so that the frame boundary lags the line by two edges. The other is a sync word that could falsely match on bits left over from reset. The bench reaches the first by toggling carrier-detect and clear-to-send at pseudo-random times over long random streams, in every pulse/envelope and sampling combination. It reaches the second by sending an all-zero word right after reset. A loopback run feeds the transmitter output into the receiver, which shows that the sync word the transmitter sends is the one the receiver locks onto.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [0:0] {RX_HUNT, RX_RUN} rx_state_e;
    typedef enum logic [1:0] {TX_WAIT, TX_SYNC, TX_DATA} tx_state_e;

    localparam logic [1:0] SYNC_LEN_EXT   = 2'b00;
    localparam logic [1:0] SYNC_LEN_SHORT = 2'b01;
endpackage

// File: rtl/sf_line_sampler.sv
module sf_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic sync_mode,
    output logic sampled
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = line_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], line_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // synchronous option: act on the line at the same edge as the data bit
    assign sampled = sync_mode ? line_in : chain_q[STAGES-1];
endmodule

// File: rtl/sf_rx.sv
module sf_rx
    import sf_pkg::*;
#(
    parameter int PAT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              start_line,
    input  logic [1:0]        len_code,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              pulse_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int SHORT_W = PAT_W / 2;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int FILL_W  = $clog2(PAT_W + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(DATA_W - 1);
    localparam logic [FILL_W-1:0] FILL_FULL  = FILL_W'(PAT_W);
    localparam logic [FILL_W-1:0] FILL_SHORT = FILL_W'(SHORT_W);

    typedef struct packed {
        rx_state_e         state;
        logic [PAT_W-1:0]  hist;
        logic [FILL_W-1:0] fill;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              valid;
    } rx_regs_t;

    rx_regs_t q, d;

    logic              ext_mode;
    logic              hit;
    logic              store;
    logic [PAT_W-1:0]  hist_new;
    logic [FILL_W-1:0] fill_new;
    logic [DATA_W-1:0] sh_new;

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        ext_mode = (len_code == SYNC_LEN_EXT);
        hist_new = {q.hist[PAT_W-2:0], rx_bit};
        fill_new = (q.fill == FILL_FULL) ? q.fill : q.fill + FILL_W'(1);
        d.hist   = hist_new;
        d.fill   = fill_new;
        sh_new   = {q.shreg[DATA_W-2:0], rx_bit};
        if (len_code == SYNC_LEN_SHORT)
            hit = (hist_new[SHORT_W-1:0] == pattern[SHORT_W-1:0]) && (fill_new >= FILL_SHORT);
        else
            hit = (hist_new == pattern) && (fill_new == FILL_FULL);
        store = 1'b0;

        case (q.state)
            RX_HUNT: begin
                if (ext_mode) begin
                    if (start_line) begin
                        d.state = RX_RUN;
                        store   = 1'b1;
                    end
                end else if (hit) begin
                    d.state = RX_RUN;
                end
            end
            RX_RUN: begin
                if (ext_mode && !pulse_mode && !start_line) begin
                    d.state = RX_HUNT;
                    d.cnt   = '0;
                end else begin
                    store = 1'b1;
                end
            end
            default: d.state = RX_HUNT;
        endcase

        if (store) begin
            d.shreg = sh_new;
            if (q.cnt == CNT_LAST) begin
                d.data  = sh_new;
                d.valid = 1'b1;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data  = q.data;
    assign rx_valid = q.valid;
endmodule

// File: rtl/sf_tx.sv
module sf_tx
    import sf_pkg::*;
#(
    parameter int PAT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_line,
    input  logic [1:0]        len_code,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              pulse_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_bit
);
    localparam int SHORT_W = PAT_W / 2;
    localparam int PIDX_W  = $clog2(PAT_W);
    localparam int CNT_W   = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         state;
        logic [PIDX_W-1:0] idx;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  left;
        logic              busy;
        logic              bit_o;
    } tx_regs_t;

    tx_regs_t q, d;

    logic              ext_mode;
    logic              abort;
    logic [PIDX_W-1:0] top_idx;

    always_comb begin
        d        = q;
        ext_mode = (len_code == SYNC_LEN_EXT);
        abort    = ext_mode && !pulse_mode && !start_line;
        top_idx  = (len_code == SYNC_LEN_SHORT) ? PIDX_W'(SHORT_W - 1) : PIDX_W'(PAT_W - 1);
        tx_ready = (q.state == TX_DATA) && !q.busy && !abort;

        case (q.state)
            TX_WAIT: begin
                d.bit_o = 1'b1;
                if (ext_mode) begin
                    if (start_line) d.state = TX_DATA;
                end else if (tx_valid) begin
                    d.state = TX_SYNC;
                    d.bit_o = pattern[top_idx];
                    d.idx   = top_idx - PIDX_W'(1);
                end
            end
            TX_SYNC: begin
                d.bit_o = pattern[q.idx];
                if (q.idx == '0) d.state = TX_DATA;
                else             d.idx   = q.idx - PIDX_W'(1);
            end
            TX_DATA: begin
                if (abort) begin
                    d.state = TX_WAIT;
                    d.busy  = 1'b0;
                    d.bit_o = 1'b1;
                end else if (q.busy) begin
                    d.bit_o = q.shreg[DATA_W-1];
                    d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                    d.left  = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) d.busy = 1'b0;
                end else if (tx_valid) begin
                    d.bit_o = tx_data[DATA_W-1];
                    d.shreg = {tx_data[DATA_W-2:0], 1'b0};
                    d.left  = CNT_W'(DATA_W - 1);
                    d.busy  = 1'b1;
                end else begin
                    d.bit_o = 1'b1;
                end
            end
            default: begin
                d.state = TX_WAIT;
                d.bit_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.bit_o <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit = q.bit_o;
endmodule

// File: rtl/sync_framer_top.sv
module sync_framer_top #(
    parameter int PAT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              cd_in,
    input  logic              cts_in,
    input  logic [1:0]        sync_len,
    input  logic [PAT_W-1:0]  sync_pattern,
    input  logic              rx_pulse,
    input  logic              tx_pulse,
    input  logic              rx_sync_sample,
    input  logic              tx_sync_sample,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_bit
);
    logic cd_s, cts_s;

    sf_line_sampler #(.STAGES(SYNC_STAGES)) cd_samp_i (
        .clk(clk), .rst_n(rst_n), .line_in(cd_in),
        .sync_mode(rx_sync_sample), .sampled(cd_s)
    );

    sf_line_sampler #(.STAGES(SYNC_STAGES)) cts_samp_i (
        .clk(clk), .rst_n(rst_n), .line_in(cts_in),
        .sync_mode(tx_sync_sample), .sampled(cts_s)
    );

    sf_rx #(.PAT_W(PAT_W), .DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .start_line(cd_s),
        .len_code(sync_len), .pattern(sync_pattern), .pulse_mode(rx_pulse),
        .rx_data(rx_byte), .rx_valid(rx_valid)
    );

    sf_tx #(.PAT_W(PAT_W), .DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .start_line(cts_s),
        .len_code(sync_len), .pattern(sync_pattern), .pulse_mode(tx_pulse),
        .tx_data(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit)
    );
endmodule

// File: rtl/sf_framer_checker.sv
module sf_framer_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cd_in,
    input logic              cts_in,
    input logic [1:0]        sync_len,
    input logic              rx_pulse,
    input logic              tx_pulse,
    input logic              rx_sync_sample,
    input logic              tx_sync_sample,
    input logic              rx_valid,
    input logic [DATA_W-1:0] tx_byte,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_bit
);
    assert_valid_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_take_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=> (tx_bit == $past(tx_byte[DATA_W-1])));

    assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=> !tx_ready);

    assert_idle_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> tx_bit);

    assert_tx_env_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_len == 2'b00 && !tx_pulse && tx_sync_sample && !cts_in) |=> (tx_bit && !tx_ready));

    assert_rx_env_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_len == 2'b00 && !rx_pulse && rx_sync_sample && !cd_in) |=> !rx_valid);
endmodule

bind sync_framer_top sf_framer_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cd_in(cd_in), .cts_in(cts_in),
    .sync_len(sync_len), .rx_pulse(rx_pulse), .tx_pulse(tx_pulse),
    .rx_sync_sample(rx_sync_sample), .tx_sync_sample(tx_sync_sample),
    .rx_valid(rx_valid), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit)
);

// File: tb/sync_framer_top_tb_top.sv
module sync_framer_top_tb_top;
    localparam int NB = 200;
    localparam int NT = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]  sync_len = 2'b00;
    logic [15:0] sync_pattern = '0;
    logic rx_pulse = 1'b0, tx_pulse = 1'b0;
    logic rx_sync_sample = 1'b1, tx_sync_sample = 1'b1;
    logic rx_drv = 1'b1, cd_in = 1'b0, cts_in = 1'b0, loop_en = 1'b0;
    logic [7:0] tx_byte = '0;
    logic tx_valid = 1'b0;
    logic [7:0] rx_byte;
    logic rx_valid, tx_ready, tx_bit;
    logic rx_bit;
    assign rx_bit = loop_en ? tx_bit : rx_drv;

    sync_framer_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .cd_in(cd_in), .cts_in(cts_in),
        .sync_len(sync_len), .sync_pattern(sync_pattern),
        .rx_pulse(rx_pulse), .tx_pulse(tx_pulse),
        .rx_sync_sample(rx_sync_sample), .tx_sync_sample(tx_sync_sample),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit)
    );

    logic rxbits[NB], cdv[NB], ctsv[NB], exp_tx[NB], got_tx[NB];
    logic [7:0] txbytes[NT];
    logic [7:0] got_rx[NB], exp_rx[NB];
    int n_got, n_exp, bi;
    int checks = 0, fails = 0;
    logic took;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic drive(input int k);
        rx_drv = rxbits[k];
        cd_in  = cdv[k];
        cts_in = ctsv[k];
        if (took) bi++;
        tx_byte  = txbytes[bi % NT];
        tx_valid = 1'b1;
        #1 took = tx_ready;
    endtask

    task automatic run(input int n);
        rst_n = 1'b0; tx_valid = 1'b0; took = 1'b0; bi = 0; n_got = 0;
        rx_drv = 1'b1; cd_in = 1'b0; cts_in = 1'b0;
        repeat (3) @(negedge clk);
        check(rx_valid == 1'b0 && tx_ready == 1'b0 && tx_bit == 1'b1, "R1 reset outputs",
              {rx_valid, tx_ready, tx_bit}, 3'b001);
        rst_n = 1'b1;
        drive(0);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            got_tx[k-1] = tx_bit;
            if (rx_valid && n_got < NB) begin
                got_rx[n_got] = rx_byte;
                n_got++;
            end
            if (k < n) drive(k);
        end
        tx_valid = 1'b0;
    endtask

    task automatic model_rx(input int n);
        logic [15:0] h = '0;
        logic [7:0] sh = '0;
        int fill = 0, cnt = 0;
        bit running = 0, st, cds, b, ext, hit;
        n_exp = 0;
        ext = (sync_len == 2'b00);
        for (int k = 0; k < n; k++) begin
            cds = rx_sync_sample ? cdv[k] : (k >= 2 ? cdv[k-2] : 1'b0);
            b = rxbits[k];
            h = {h[14:0], b};
            if (fill < 16) fill++;
            hit = (sync_len == 2'b01) ? (h[7:0] == sync_pattern[7:0] && fill >= 8)
                                      : (h == sync_pattern && fill >= 16);
            st = 0;
            if (!running) begin
                if (ext) begin
                    if (cds) begin running = 1; st = 1; end
                end else if (hit) running = 1;
            end else if (ext && !rx_pulse && !cds) begin
                running = 0; cnt = 0;
            end else st = 1;
            if (st) begin
                sh = {sh[6:0], b};
                cnt++;
                if (cnt == 8) begin exp_rx[n_exp] = sh; n_exp++; cnt = 0; end
            end
        end
    endtask

    task automatic model_tx(input int n);
        int state = 0, idx = 0, rem = 0, b_i = 0, plen;
        logic [7:0] cur = '0;
        bit cs, ext, abort_now, e;
        ext = (sync_len == 2'b00);
        plen = (sync_len == 2'b01) ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            cs = tx_sync_sample ? ctsv[k] : (k >= 2 ? ctsv[k-2] : 1'b0);
            abort_now = ext && !tx_pulse && !cs;
            e = 1'b1;
            case (state)
                0: if (ext) begin
                       if (cs) state = 2;
                   end else begin
                       state = 1; e = sync_pattern[plen-1]; idx = plen - 2;
                   end
                1: begin
                       e = sync_pattern[idx];
                       if (idx == 0) state = 2; else idx--;
                   end
                default: if (abort_now) begin
                       state = 0; rem = 0;
                   end else if (rem > 0) begin
                       e = cur[rem-1]; rem--;
                   end else begin
                       cur = txbytes[b_i % NT]; b_i++; e = cur[7]; rem = 7;
                   end
            endcase
            exp_tx[k] = e;
        end
    endtask

    task automatic compare_rx(input string tag);
        check(n_got == n_exp, $sformatf("%s byte count", tag), n_got, n_exp);
        for (int i = 0; i < n_got && i < n_exp; i++)
            check(got_rx[i] == exp_rx[i], $sformatf("%s byte %0d", tag, i), got_rx[i], exp_rx[i]);
    endtask

    task automatic compare_tx(input int n, input string tag);
        int bad = -1;
        for (int k = 0; k < n; k++)
            if (bad < 0 && got_tx[k] !== exp_tx[k]) bad = k;
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, $sformatf("%s bit at edge %0d", tag, bad), got_tx[bad], exp_tx[bad]);
    endtask

    task automatic fill_random(input int n, input int toggle_div);
        logic lc = 1'b0, lt = 1'b0;
        for (int k = 0; k < n; k++) begin
            rxbits[k] = rnd() % 2;
            if (rnd() % toggle_div == 0) lc = ~lc;
            if (rnd() % toggle_div == 0) lt = ~lt;
            cdv[k] = lc;
            ctsv[k] = lt;
        end
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        for (int i = 0; i < NT; i++) txbytes[i] = rnd() % 256;

        // R2 R3: in-line receive over all length codes and several patterns
        for (int len = 1; len <= 3; len++) begin
            for (int p = 0; p < 4; p++) begin
                int plen;
                plen = (len == 1) ? 8 : 16;
                sync_len = len[1:0];
                sync_pattern = rnd() % 65536;
                fill_random(NB, 12);
                for (int k = 0; k < plen; k++) rxbits[20 + k] = sync_pattern[plen-1-k];
                model_rx(120);
                run(120);
                compare_rx(len == 1 ? "R2 short" : "R3 long");
            end
        end

        // R2: match needs a full pattern's worth of bits after reset
        sync_len = 2'b10;
        sync_pattern = 16'h0000;
        for (int k = 0; k < NB; k++) rxbits[k] = 1'b0;
        model_rx(64);
        run(64);
        check(n_got == 6, "R2 fill count", n_got, 6);
        compare_rx("R2 zero word");

        // R4 R5 R6 R7: external carrier-detect in every option combination
        sync_len = 2'b00;
        for (int m = 0; m < 4; m++) begin
            rx_pulse = m[0];
            rx_sync_sample = m[1];
            fill_random(NB, 9);
            for (int k = 0; k < 6; k++) cdv[k] = 1'b0;
            model_rx(180);
            run(180);
            compare_rx(rx_pulse ? (rx_sync_sample ? "R4 R5" : "R5 R7") :
                                  (rx_sync_sample ? "R4 R6" : "R6 R7"));
        end

        // R8: in-line transmit, pattern ahead of data
        for (int len = 1; len <= 2; len++) begin
            for (int p = 0; p < 2; p++) begin
                sync_len = len[1:0];
                sync_pattern = rnd() % 65536;
                fill_random(NB, 7);
                model_tx(120);
                run(120);
                compare_tx(120, "R8 sync then data");
            end
        end

        // R9 R10 R12 R13 R7: external clear-to-send in every option combination
        sync_len = 2'b00;
        for (int m = 0; m < 4; m++) begin
            tx_pulse = m[0];
            tx_sync_sample = m[1];
            fill_random(NB, 10);
            for (int k = 0; k < 4; k++) ctsv[k] = 1'b0;
            model_tx(180);
            run(180);
            compare_tx(180, tx_pulse ? "R9 R10 R13" : (tx_sync_sample ? "R10 R12" : "R12 R7"));
        end

        // R11: never started, line stays high
        tx_pulse = 1'b1;
        tx_sync_sample = 1'b1;
        for (int k = 0; k < NB; k++) ctsv[k] = 1'b0;
        run(50);
        begin
            int ones = 0;
            for (int k = 0; k < 50; k++) ones += got_tx[k];
            check(ones == 50, "R11 idle ones", ones, 50);
        end

        // R8 R2 R3: loopback, receiver locks onto the transmitted word
        sync_len = 2'b10;
        sync_pattern = 16'h1ACF;
        loop_en = 1'b1;
        for (int k = 0; k < NB; k++) ctsv[k] = 1'b0;
        run(160);
        loop_en = 1'b0;
        check(n_got == 17, "R8 loopback byte count", n_got, 17);
        for (int i = 0; i < n_got && i < NB; i++)
            check(got_rx[i] == txbytes[i], $sformatf("R8 loopback byte %0d", i), got_rx[i], txbytes[i]);

        finish_up();
    end
endmodule